// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block sits on the host side of a parallel NOR flash. After software or another controller has issued a program or erase command, a start pulse hands the job of watching the flash's embedded operation to this poller. The poller reads the 8-bit status bus in back-to-back pairs. It decides that the operation has finished when the toggle bit (bit 6) holds the same value across both reads of a pair. If the toggle bit differs, it looks at the timeout flag (bit 5) of the later read. A raised flag triggers one fresh pair of reads. If that fresh pair still toggles, the poller treats the operation as failed and writes the reset command so the flash returns to array reads.

Read cycles use a request/valid handshake: `rd_req_o` stays high until `rd_valid_i` arrives with the data. The reset command is one write of 0xF0 through a request/acknowledge handshake. The host may hold `pause_i` to stop polling between pairs. When polling resumes it starts again from a fresh read pair and a cleared round count. A round limit set by parameter makes sure the poller always reaches a result.

Top module: `tgl_poller`

## Requirements
- R1: While reset is active and on the first cycle after it is released, `busy_o`, `done_o`, `fail_o`, `rd_req_o` and `wr_req_o` are all low.
- R2: A `start_i` pulse while idle raises `busy_o` and `rd_req_o` on the next cycle. A `start_i` pulse while busy is ignored, which means it issues no extra reads and produces no extra result.
- R3: Each check uses a pair of reads, each held until `rd_valid_i`. If bit 6 matches across the pair, `done_o` pulses on the cycle after the second read. On that same cycle `busy_o` and `rd_req_o` are low, so the bus is given back for normal reads.
- R4: If bit 6 differs across a pair and bit 5 of the second read is 1, the poller issues a fresh pair of reads. If bit 6 matches in that fresh pair, the result is done.
- R5: If the fresh pair from R4 still toggles, the poller holds `wr_req_o` with `wr_data_o` = 0xF0 until `wr_ack_i`. `fail_o` then pulses on the cycle after the acknowledge.
- R6: If bit 6 differs across a pair and bit 5 is 0, the poller counts one round and reads another pair. When the count reaches MAX_ROUNDS, the poller takes the R5 reset-write and fail path instead.
- R7: If `pause_i` is high when a pair ends with bit 6 toggling and bit 5 low, the poller stops issuing reads. It stays stopped for as long as `pause_i` stays high, and `busy_o` remains high.
- R8: When `pause_i` falls, polling restarts with a new pair of reads. No stored bit-6 value is reused, and the round count starts again from zero.
- R9: `done_o` and `fail_o` are single-cycle pulses and are never high together. Exactly one of them is produced per started poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin polling (pulse) |
| pause_i | input | 1 | Hold polling between read pairs |
| rd_req_o | output | 1 | Status read request |
| rd_data_i | input | 8 | Status byte from flash |
| rd_valid_i | input | 1 | Read data valid |
| wr_req_o | output | 1 | Command write request |
| wr_data_o | output | 8 | Command write data |
| wr_ack_i | input | 1 | Command write accepted |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | Operation completed (pulse) |
| fail_o | output | 1 | Operation failed (pulse) |

## Verification
The bench builds the poller with MAX_ROUNDS = 4 instead of the default. With that setting, the round-limit failure and the last-round-still-succeeds boundary both come within eight reads. It also separates a round count that was correctly cleared on resume (eight reads to fail) from one that was not (six reads). A flash model driven by a settle-read index and a timeout-read index produces each toggle, timeout and recheck ordering.

// File: rtl/tgl_poll_pkg.sv
package tgl_poll_pkg;
  localparam int unsigned DATA_W = 8;
  localparam logic [DATA_W-1:0] CMD_RESET = 8'hF0;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_A,
    S_RD_B,
    S_PAUSE,
    S_CMD_RST
  } poll_state_e;
endpackage

// File: rtl/tgl_dq_sampler.sv
module tgl_dq_sampler #(
  parameter int unsigned DW      = 8,
  parameter int unsigned TGL_BIT = 6,
  parameter int unsigned TO_BIT  = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [DW-1:0] data_i,
  output logic          toggled_o,
  output logic          to_high_o
);
  logic first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    first_q <= 1'b0;
    else if (cap_i) first_q <= data_i[TGL_BIT];
  end

  assign toggled_o = first_q ^ data_i[TGL_BIT];
  assign to_high_o = data_i[TO_BIT];
endmodule

// File: rtl/tgl_round_ctr.sv
module tgl_round_ctr #(
  parameter int unsigned MAX_ROUNDS = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CNT_W = (MAX_ROUNDS > 1) ? $clog2(MAX_ROUNDS + 1) : 1;

  generate
    if (MAX_ROUNDS == 0) begin : g_no_limit
      logic unused_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) unused_q <= 1'b0;
        else         unused_q <= clr_i ^ inc_i;
      end
      assign last_o = 1'b0 & unused_q;
    end else begin : g_limit
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (inc_i) cnt_q <= cnt_q + 1'b1;
      end
      // the next counted round is the last allowed one
      assign last_o = (cnt_q == CNT_W'(MAX_ROUNDS - 1));
    end
  endgenerate
endmodule

// File: rtl/tgl_poll_fsm.sv
module tgl_poll_fsm
  import tgl_poll_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic pause_i,
  input  logic rd_valid_i,
  input  logic wr_ack_i,
  input  logic toggled_i,
  input  logic to_high_i,
  input  logic last_round_i,
  output logic cap_o,
  output logic round_inc_o,
  output logic round_clr_o,
  output logic rd_req_o,
  output logic wr_req_o,
  output logic busy_o,
  output logic done_o,
  output logic fail_o
);
  poll_state_e state_q, state_d;
  logic recheck_q, recheck_d;
  logic done_q, done_d, fail_q, fail_d;
  logic pair_end;

  assign pair_end = (state_q == S_RD_B) && rd_valid_i;

  always_comb begin
    state_d     = state_q;
    recheck_d   = recheck_q;
    done_d      = 1'b0;
    fail_d      = 1'b0;
    round_inc_o = 1'b0;
    round_clr_o = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d     = S_RD_A;
        recheck_d   = 1'b0;
        round_clr_o = 1'b1;
      end
      S_RD_A: if (rd_valid_i) state_d = S_RD_B;
      S_RD_B: if (pair_end) begin
        if (!toggled_i) begin
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else if (recheck_q) begin
          state_d = S_CMD_RST;
        end else if (to_high_i) begin
          recheck_d = 1'b1;
          state_d   = S_RD_A;
        end else if (last_round_i) begin
          state_d = S_CMD_RST;
        end else begin
          round_inc_o = 1'b1;
          state_d     = pause_i ? S_PAUSE : S_RD_A;
        end
      end
      S_PAUSE: if (!pause_i) begin
        state_d     = S_RD_A;
        round_clr_o = 1'b1;
      end
      S_CMD_RST: if (wr_ack_i) begin
        fail_d  = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      recheck_q <= 1'b0;
      done_q    <= 1'b0;
      fail_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      recheck_q <= recheck_d;
      done_q    <= done_d;
      fail_q    <= fail_d;
    end
  end

  assign cap_o    = (state_q == S_RD_A) && rd_valid_i;
  assign rd_req_o = (state_q == S_RD_A) || (state_q == S_RD_B);
  assign wr_req_o = (state_q == S_CMD_RST);
  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = done_q;
  assign fail_o   = fail_q;
endmodule

// File: rtl/tgl_poller.sv
module tgl_poller
  import tgl_poll_pkg::*;
#(
  parameter int unsigned MAX_ROUNDS = 1024,
  parameter int unsigned TGL_BIT    = 6,
  parameter int unsigned TO_BIT     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pause_i,
  output logic              rd_req_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_valid_i,
  output logic              wr_req_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o
);
  logic cap, toggled, to_high, last_round, round_inc, round_clr;

  tgl_dq_sampler #(.DW(DATA_W), .TGL_BIT(TGL_BIT), .TO_BIT(TO_BIT)) u_sampler (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap),
    .data_i    (rd_data_i),
    .toggled_o (toggled),
    .to_high_o (to_high)
  );

  tgl_round_ctr #(.MAX_ROUNDS(MAX_ROUNDS)) u_rounds (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (round_clr),
    .inc_i  (round_inc),
    .last_o (last_round)
  );

  tgl_poll_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .pause_i      (pause_i),
    .rd_valid_i   (rd_valid_i),
    .wr_ack_i     (wr_ack_i),
    .toggled_i    (toggled),
    .to_high_i    (to_high),
    .last_round_i (last_round),
    .cap_o        (cap),
    .round_inc_o  (round_inc),
    .round_clr_o  (round_clr),
    .rd_req_o     (rd_req_o),
    .wr_req_o     (wr_req_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fail_o       (fail_o)
  );

  assign wr_data_o = CMD_RESET;
endmodule

// File: rtl/tgl_poller_chk.sv
module tgl_poller_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       rd_req_o,
  input logic       rd_valid_i,
  input logic       wr_req_o,
  input logic [7:0] wr_data_o,
  input logic       wr_ack_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       fail_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!rd_req_o && !wr_req_o));
  p_start_reads_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && rd_req_o));
  p_rd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_valid_i) |=> rd_req_o);
  p_done_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!rd_req_o && !busy_o));
  p_wr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_data_o)));
  p_wr_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> (wr_data_o == 8'hF0));
  p_fail_after_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> $past(wr_req_o && wr_ack_i));
  p_no_rd_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o));
  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_fail_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !fail_o);
endmodule

bind tgl_poller tgl_poller_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .rd_req_o   (rd_req_o),
  .rd_valid_i (rd_valid_i),
  .wr_req_o   (wr_req_o),
  .wr_data_o  (wr_data_o),
  .wr_ack_i   (wr_ack_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .fail_o     (fail_o)
);

// File: tb/tgl_poller_bench.sv
`timescale 1ns/1ps
module tgl_poller_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, pause = 1'b0;
  logic rd_req, rd_valid = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic wr_req, wr_ack = 1'b0;
  logic [7:0] wr_data;
  logic busy, done, fail;

  int total = 0, bad = 0, cyc = 0;
  int rd_cnt = 0, wr_cnt = 0;
  int rd_base = 0;
  int settle_at = 0, to_at = 99;
  logic [7:0] last_wr = 8'h00;

  always #2.5 clk = ~clk;

  tgl_poller #(.MAX_ROUNDS(4)) u_tgl_poller (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pause_i(pause),
    .rd_req_o(rd_req), .rd_data_i(rd_data), .rd_valid_i(rd_valid),
    .wr_req_o(wr_req), .wr_data_o(wr_data), .wr_ack_i(wr_ack),
    .busy_o(busy), .done_o(done), .fail_o(fail)
  );

  // flash model: read i toggles bit 6 until settle_at, bit 5 rises at to_at
  always @(negedge clk) begin
    if (rd_req && !rd_valid) begin
      automatic int i = rd_cnt - rd_base;
      rd_valid <= 1'b1;
      rd_data  <= 8'h00;
      rd_data[6] <= (i < settle_at) ? i[0] : settle_at[0];
      rd_data[5] <= (i >= to_at);
    end else begin
      rd_valid <= 1'b0;
    end
    if (wr_req && !wr_ack) begin
      wr_ack  <= 1'b1;
      last_wr <= wr_data;
    end else begin
      wr_ack <= 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_req && rd_valid) rd_cnt <= rd_cnt + 1;
    if (wr_req && wr_ack)   wr_cnt <= wr_cnt + 1;
  end

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  // {settle_at, to_at, expect_fail, expect_reads}
  localparam int VEC [8][4] = '{
    '{0, 99, 0, 2}, '{3, 99, 0, 6}, '{2, 1, 0, 4}, '{20, 1, 1, 4},
    '{50, 99, 1, 8}, '{6, 3, 1, 6}, '{6, 5, 0, 8}, '{6, 99, 0, 8}
  };

  int n_done, n_fail, busy_gap, rd_at_done;

  task automatic wait_result();
    n_done = 0; n_fail = 0; busy_gap = 0; rd_at_done = 0;
    for (int k = 0; k < 2000 && (n_done + n_fail) == 0; k++) begin
      @(negedge clk);
      if (done) begin n_done++; rd_at_done = rd_req; end
      if (fail) n_fail++;
      if (!busy && !done && !fail) busy_gap++;
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done) n_done++;
      if (fail) n_fail++;
    end
  endtask

  task automatic run_poll(input int s, input int t);
    settle_at = s; to_at = t; rd_base = rd_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_result();
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !fail && !rd_req && !wr_req, "R1 outputs in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !fail && !rd_req && !wr_req, "R1 outputs after reset", busy, 0);

    for (int v = 0; v < 8; v++) begin
      automatic int w0 = wr_cnt;
      run_poll(VEC[v][0], VEC[v][1]);
      check(rd_cnt - rd_base == VEC[v][3], $sformatf("R3/R4/R5/R6 reads vec %0d", v),
            rd_cnt - rd_base, VEC[v][3]);
      check(n_fail == VEC[v][2] && n_done == 1 - VEC[v][2],
            $sformatf("R9 single result vec %0d", v), n_fail * 10 + n_done, VEC[v][2] * 9 + 1);
      check(wr_cnt - w0 == VEC[v][2], $sformatf("R5 reset writes vec %0d", v),
            wr_cnt - w0, VEC[v][2]);
      if (VEC[v][2] == 1) check(last_wr == 8'hF0, "R5 reset code", last_wr, 8'hF0);
      else check(rd_at_done == 0, "R3 bus released at done", rd_at_done, 0);
      check(busy_gap == 0, $sformatf("R9 busy held vec %0d", v), busy_gap, 0);
    end

    // R2: start pulses while busy are ignored
    settle_at = 0; to_at = 99; rd_base = rd_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk);
    check(busy && rd_req, "R2 busy and read after start", busy, 1);
    @(negedge clk); start = 1'b0;
    wait_result();
    repeat (6) @(negedge clk);
    check(rd_cnt - rd_base == 2 && n_done == 1 && !busy, "R2 restart ignored while busy",
          rd_cnt - rd_base, 2);

    // R7/R8: pause then resume with a settled flash
    pause = 1'b1;
    settle_at = 50; to_at = 99; rd_base = rd_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    check(rd_cnt - rd_base == 2, "R7 reads stop while paused", rd_cnt - rd_base, 2);
    check(busy && !rd_req && !done && !fail, "R7 busy held while paused", busy, 1);
    settle_at = 0; rd_base = rd_cnt;
    pause = 1'b0;
    wait_result();
    check(rd_cnt - rd_base == 2 && n_done == 1, "R8 fresh pair after resume",
          rd_cnt - rd_base, 2);

    // R8: round count cleared on resume
    pause = 1'b1;
    settle_at = 50; rd_base = rd_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (12) @(negedge clk);
    rd_base = rd_cnt;
    pause = 1'b0;
    wait_result();
    check(rd_cnt - rd_base == 8 && n_fail == 1, "R8 rounds restart from zero",
          rd_cnt - rd_base, 8);
    check(last_wr == 8'hF0, "R6 timeout reset write", last_wr, 8'hF0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule